// File: doc/BRIEF.md
# Two-Port Read/Write Memory from One-Write/One-Read Banks

This block is a memory of 130 words by 6 bits. It has two symmetric ports, A and B. In any cycle, each port may read or write any word, independently of the other port. The storage is four simple banks. Each bank has one write port and one read port. Every word is kept twice: port A stores its data in two banks, and port B stores its data in the other two. Each port reads one copy from each writer's pair. A small table built from flip-flops holds one ownership bit per word, recording which port wrote that word most recently. The read path uses this bit to choose the current copy.

Both ports share one clock. Reads are synchronous, with one cycle of latency. The address space is 8 bits wide. Locations at 130 and above do not exist: writes to them are dropped and reads from them return zero. When both ports write the same word in the same cycle, port B's data is the one kept.

Top module: `lvt_dp_ram`

## Requirements
- R1: In one cycle, port A and port B can each write a different in-range word, and both writes are kept.
- R2: The read data for an address applied at a rising clock edge appears on that port's read data output after that edge and holds until the next edge.
- R3: A word written through port A reads back with port A's data on both ports until the word is written again.
- R4: A word written through port B reads back with port B's data on both ports until the word is written again.
- R5: After several writes to the same word from either port, in any order, a read returns the data of the most recent write.
- R6: When both ports write the same in-range word in the same cycle, later reads of that word on either port return port B's data.
- R7: A read of a word that is being written in the same cycle, by either port, returns the value the word held before that write.
- R8: A write to an address of 130 or above changes no word in the range 0 to 129.
- R9: A read from an address of 130 or above returns 0 on the next cycle.
- R10: Synchronous active-high reset drives both read outputs to 0 and clears every ownership bit to port A. Stored data is not cleared, so after reset each word reads the value that port A last wrote to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 8 | Port A word address |
| a_we | input | 1 | Port A write enable |
| a_wdata | input | 6 | Port A write data |
| a_rdata | output | 6 | Port A read data, one cycle after the address |
| b_addr | input | 8 | Port B word address |
| b_we | input | 1 | Port B write enable |
| b_wdata | input | 6 | Port B write data |
| b_rdata | output | 6 | Port B read data, one cycle after the address |

## Verification
Read data is due in the cycle after the edge that captures the address. A write becomes visible to a read whose address is captured one edge later. The bench drives each operation on a falling edge and samples both read outputs 1 ns after the following rising edge. Its model is updated only after that sample, so a read that coincides with a write is compared against the old contents (R7). The assertions count the same one-edge and two-edge windows with `$past`: the write data from two edges back must appear at the other port when that port reads the written word one edge later.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

    localparam int unsigned LVT_WORDS  = 130;
    localparam int unsigned LVT_DATA_W = 6;
    localparam int unsigned LVT_ADDR_W = 8;
    localparam int unsigned LVT_PORTS  = 2;

    // Which port owns the live copy of a word.
    typedef enum logic {
        SEL_PORT_A = 1'b0,
        SEL_PORT_B = 1'b1
    } owner_e;

    // Per-port control decoded from the address.
    typedef struct packed {
        logic wen;   // qualified write (enable and in range)
        logic hit;   // address is inside the array
    } port_ctl_t;

    // Bank holding the copy written by `writer` and read by `reader`.
    function automatic int unsigned bank_of(input int unsigned writer,
                                            input int unsigned reader);
        return writer * LVT_PORTS + reader;
    endfunction

endpackage

// File: rtl/lvt_bank.sv
module lvt_bank #(
    parameter int unsigned WORDS  = 130,
    parameter int unsigned DATA_W = 6,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [WORDS];

    // Read returns the pre-write contents on an address match.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/lvt_owner_table.sv
module lvt_owner_table
    import lvt_pkg::*;
#(
    parameter int unsigned WORDS  = 130,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_wen,
    input  logic [ADDR_W-1:0] a_waddr,
    input  logic              b_wen,
    input  logic [ADDR_W-1:0] b_waddr,
    input  logic [ADDR_W-1:0] a_raddr,
    input  logic [ADDR_W-1:0] b_raddr,
    output owner_e            a_owner_q,
    output owner_e            b_owner_q
);

    logic [WORDS-1:0] owner;

    for (genvar i = 0; i < WORDS; i++) begin : g_bit
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                owner[i] <= SEL_PORT_A;
            end else if (b_wen && b_waddr == IDX) begin
                owner[i] <= SEL_PORT_B;      // B takes precedence
            end else if (a_wen && a_waddr == IDX) begin
                owner[i] <= SEL_PORT_A;
            end
        end
    end

    // Registered alongside the bank reads so select and data align.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_owner_q <= SEL_PORT_A;
            b_owner_q <= SEL_PORT_A;
        end else begin
            a_owner_q <= owner_e'(owner[a_raddr]);
            b_owner_q <= owner_e'(owner[b_raddr]);
        end
    end

endmodule

// File: rtl/lvt_read_port.sv
module lvt_read_port
    import lvt_pkg::*;
#(
    parameter int unsigned DATA_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  owner_e            owner_q,
    input  logic [DATA_W-1:0] copy_a,
    input  logic [DATA_W-1:0] copy_b,
    output logic [DATA_W-1:0] rdata
);

    logic hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= hit;
        end
    end

    always_comb begin
        if (!hit_q) begin
            rdata = '0;
        end else if (owner_q == SEL_PORT_B) begin
            rdata = copy_b;
        end else begin
            rdata = copy_a;
        end
    end

endmodule

// File: rtl/lvt_dp_ram.sv
module lvt_dp_ram
    import lvt_pkg::*;
#(
    parameter int unsigned WORDS  = LVT_WORDS,
    parameter int unsigned DATA_W = LVT_DATA_W,
    parameter int unsigned ADDR_W = LVT_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_we,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_we,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    localparam int unsigned NPORT = LVT_PORTS;
    localparam int unsigned NBANK = NPORT * NPORT;
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(WORDS);

    logic [ADDR_W-1:0] p_addr  [NPORT];
    logic [DATA_W-1:0] p_wdata [NPORT];
    logic              p_we    [NPORT];
    logic [ADDR_W-1:0] p_raddr [NPORT];
    port_ctl_t         p_ctl   [NPORT];
    owner_e            p_owner [NPORT];
    logic [DATA_W-1:0] p_rdata [NPORT];
    logic [DATA_W-1:0] bank_rd [NBANK];

    assign p_addr[0]  = a_addr;
    assign p_addr[1]  = b_addr;
    assign p_wdata[0] = a_wdata;
    assign p_wdata[1] = b_wdata;
    assign p_we[0]    = a_we;
    assign p_we[1]    = b_we;

    // Address decode: out-of-range writes are dropped, reads parked at 0.
    for (genvar p = 0; p < NPORT; p++) begin : g_ctl
        always_comb begin
            p_ctl[p].hit = (p_addr[p] < LIMIT);
            p_ctl[p].wen = p_we[p] && p_ctl[p].hit;
            p_raddr[p]   = p_ctl[p].hit ? p_addr[p] : '0;
        end
    end

    // Bank g is written by port g/NPORT and read by port g%NPORT.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam int unsigned WR = g / NPORT;
        localparam int unsigned RD = g % NPORT;
        lvt_bank #(
            .WORDS (WORDS),
            .DATA_W(DATA_W),
            .ADDR_W(ADDR_W)
        ) u_bank (
            .clk  (clk),
            .we   (p_ctl[WR].wen),
            .waddr(p_addr[WR]),
            .wdata(p_wdata[WR]),
            .raddr(p_raddr[RD]),
            .rdata(bank_rd[g])
        );
    end

    lvt_owner_table #(
        .WORDS (WORDS),
        .ADDR_W(ADDR_W)
    ) u_owner (
        .clk      (clk),
        .rst      (rst),
        .a_wen    (p_ctl[0].wen),
        .a_waddr  (p_addr[0]),
        .b_wen    (p_ctl[1].wen),
        .b_waddr  (p_addr[1]),
        .a_raddr  (p_raddr[0]),
        .b_raddr  (p_raddr[1]),
        .a_owner_q(p_owner[0]),
        .b_owner_q(p_owner[1])
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_rport
        lvt_read_port #(
            .DATA_W(DATA_W)
        ) u_rport (
            .clk    (clk),
            .rst    (rst),
            .hit    (p_ctl[p].hit),
            .owner_q(p_owner[p]),
            .copy_a (bank_rd[bank_of(0, p)]),
            .copy_b (bank_rd[bank_of(1, p)]),
            .rdata  (p_rdata[p])
        );
    end

    assign a_rdata = p_rdata[0];
    assign b_rdata = p_rdata[1];

endmodule

// File: rtl/lvt_dp_ram_chk.sv
module lvt_dp_ram_chk #(
    parameter int unsigned WORDS  = 130,
    parameter int unsigned DATA_W = 6,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] a_addr,
    input logic              a_we,
    input logic [DATA_W-1:0] a_wdata,
    input logic [DATA_W-1:0] a_rdata,
    input logic [ADDR_W-1:0] b_addr,
    input logic              b_we,
    input logic [DATA_W-1:0] b_wdata,
    input logic [DATA_W-1:0] b_rdata
);

    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(WORDS);

    AST_A_OOB_ZERO: assert property (@(posedge clk) disable iff (rst)
        (a_addr >= LIMIT) |=> (a_rdata == '0)); // R9

    AST_B_OOB_ZERO: assert property (@(posedge clk) disable iff (rst)
        (b_addr >= LIMIT) |=> (b_rdata == '0)); // R9

    AST_A_WRITE_SEEN_BY_B: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(a_we) && ($past(a_addr) < LIMIT)
         && !($past(b_we) && $past(b_addr) == $past(a_addr))
         && (b_addr == $past(a_addr)))
        |=> (b_rdata == $past(a_wdata, 2))); // R3

    AST_B_WRITE_SEEN_BY_A: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(b_we) && ($past(b_addr) < LIMIT)
         && (a_addr == $past(b_addr)))
        |=> (a_rdata == $past(b_wdata, 2))); // R4

    AST_COLLIDE_B_WINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(a_we) && $past(b_we)
         && ($past(a_addr) == $past(b_addr)) && ($past(a_addr) < LIMIT)
         && (a_addr == $past(a_addr)))
        |=> (a_rdata == $past(b_wdata, 2))); // R6

endmodule

bind lvt_dp_ram lvt_dp_ram_chk #(
    .WORDS (WORDS),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/lvt_dp_ram_test.sv
`timescale 1ns/1ps
module lvt_dp_ram_test;

    localparam int WORDS = 130;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a_addr = '0, b_addr = '0;
    logic       a_we = 1'b0, b_we = 1'b0;
    logic [5:0] a_wdata = '0, b_wdata = '0;
    logic [5:0] a_rdata, b_rdata;

    int checks = 0;
    int failures = 0;

    // Model built from the requirements: last data per writer, last owner.
    logic [5:0] last_a [WORDS];
    logic [5:0] last_b [WORDS];
    bit         has_a  [WORDS];
    bit         has_b  [WORDS];
    bit         own_b  [WORDS];

    always #5 clk = ~clk;

    lvt_dp_ram uut (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    function automatic bit known(input int adr);
        if (adr >= WORDS) return 1'b1;
        return own_b[adr] ? has_b[adr] : has_a[adr];
    endfunction

    function automatic logic [5:0] expect_word(input int adr);
        if (adr >= WORDS) return 6'd0;
        return own_b[adr] ? last_b[adr] : last_a[adr];
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, sample just after the rising edge,
    // compare against the model before applying this cycle's writes.
    task automatic op(input int aa, input logic awe, input logic [5:0] ad,
                      input int ba, input logic bwe, input logic [5:0] bd,
                      input string tag);
        @(negedge clk);
        a_addr = 8'(aa); a_we = awe; a_wdata = ad;
        b_addr = 8'(ba); b_we = bwe; b_wdata = bd;
        @(posedge clk);
        #1;
        if (known(aa)) check(tag, $sformatf("port A addr %0d", aa), a_rdata, expect_word(aa));
        if (known(ba)) check(tag, $sformatf("port B addr %0d", ba), b_rdata, expect_word(ba));
        if (awe && aa < WORDS) begin
            last_a[aa] = ad; has_a[aa] = 1'b1; own_b[aa] = 1'b0;
        end
        if (bwe && ba < WORDS) begin
            last_b[ba] = bd; has_b[ba] = 1'b1; own_b[ba] = 1'b1;
        end
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < WORDS; i++) begin
            op(i, 1'b0, 6'd0, WORDS - 1 - i, 1'b0, 6'd0, tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            has_a[i] = 1'b0; has_b[i] = 1'b0; own_b[i] = 1'b0;
            last_a[i] = '0; last_b[i] = '0;
        end
        // R10: outputs held at zero while reset is asserted
        repeat (3) @(posedge clk);
        #1;
        check("R10", "port A in reset", a_rdata, 6'd0);
        check("R10", "port B in reset", b_rdata, 6'd0);
        @(negedge clk);
        rst = 1'b0;

        // R3: A fills every word, B reads the word written one cycle earlier
        for (int i = 0; i < WORDS; i++) begin
            op(i, 1'b1, 6'((i * 5 + 3) % 64), (i == 0) ? 0 : i - 1, 1'b0, 6'd0, "R3");
        end
        read_all("R3");

        // R7 and R4: B overwrites even words while A reads the same word
        for (int i = 0; i < WORDS; i += 2) begin
            op(i, 1'b0, 6'd0, i, 1'b1, 6'((i * 11 + 7) % 64), "R7");
        end
        // R2: address changes every cycle, data follows one cycle later
        read_all("R2");
        read_all("R4");

        // R5: A rewrites every third word after B, B rewrites some again
        for (int i = 0; i < WORDS; i += 3) begin
            op(i, 1'b1, 6'((i * 7 + 1) % 64), i, 1'b0, 6'd0, "R5");
        end
        for (int i = 0; i < WORDS; i += 6) begin
            op(i, 1'b0, 6'd0, i, 1'b1, 6'((i * 13 + 5) % 64), "R5");
        end
        read_all("R5");

        // R6: same-word collisions, then both ports read that word
        for (int i = 0; i < WORDS; i += 7) begin
            op(i, 1'b1, 6'((i * 3 + 9) % 64), i, 1'b1, 6'((i * 3 + 40) % 64), "R6");
            op(i, 1'b0, 6'd0, i, 1'b0, 6'd0, "R6");
        end

        // R1: simultaneous writes to different words on both ports
        for (int i = 0; i < 65; i++) begin
            op(i, 1'b1, 6'((i * 9 + 2) % 64), i + 65, 1'b1, 6'((i * 17 + 4) % 64), "R1");
        end
        read_all("R1");

        // R9 and R8: out-of-range writes and reads on both ports
        for (int i = WORDS; i < 256; i++) begin
            op(i, 1'b1, 6'h3f, 255 - (i - WORDS), 1'b1, 6'h2a, "R9");
        end
        read_all("R8");

        // R10: reset clears ownership; stored A copies remain readable
        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R10", "port A during reset", a_rdata, 6'd0);
        check("R10", "port B during reset", b_rdata, 6'd0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < WORDS; i++) own_b[i] = 1'b0;
        read_all("R10");

        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule